// File: doc/BRIEF.md
# Bounded Offset Address Generator

This block produces the memory address sequence for one block transfer. A control processor sets it up over a narrow system bus. The two top bits of the system address pick one of four slots. Three slots hold preset values: a base address, the first offset of the window, and the last offset of the window. The fourth slot is a command that starts a walk over that window.

During a walk the block drives a memory address equal to the base plus the current offset. It holds a busy flag high for the whole walk. A one-cycle `accessDone` pulse from the data path moves the walk to the next offset. When the next offset would pass the last offset, the busy flag drops and the walk ends. The presets are frozen while a walk is running, so the window cannot change under the accumulator.

Top module: `bounded_offset_agen`

## Requirements
- R1: After the synchronous active-low reset, all three presets and the offset accumulator are zero, `busy` is 0 and `memAddr` is 0.
- R2: A write (`sysWrEn`=1) with `sysAddr[SYS_AW-1:SYS_AW-2]`=00 while idle loads the base from `sysData`. From the next cycle, `memAddr` shows the new base plus the current offset.
- R3: While idle, a write with slot code 01 loads the first offset and a write with slot code 10 loads the last offset, each from `sysData[OFS_W-1:0]`. A write to one slot leaves the other presets unchanged.
- R4: While idle, a write with slot code 11, when first offset <= last offset, sets `busy` to 1 in the next cycle. In that cycle `memAddr` equals base + first offset.
- R5: While busy, an `accessDone` pulse whose next offset (current + 1) is not greater than the last offset advances the offset by one and keeps `busy` high. Without a pulse, the offset and `busy` hold.
- R6: While busy, an `accessDone` pulse whose next offset is greater than the last offset drops `busy` in the next cycle. `memAddr` stays at base + last offset.
- R7: A slot-11 write when first offset > last offset leaves `busy` low and leaves `memAddr` unchanged.
- R8: While busy, all system writes are ignored, including a new slot-11 command. While idle, `accessDone` is ignored.
- R9: `memAddr` is (base + zero-extended offset) modulo 2^ADDR_W.
- R10: The bound compare does not wrap. A window that ends at the largest offset (all ones) ends after that offset, without returning to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| sysWrEn | input | 1 | System bus write strobe |
| sysAddr | input | SYS_AW | System address; the two MSBs select the slot |
| sysData | input | ADDR_W | System write data |
| accessDone | input | 1 | One pulse per completed memory access |
| busy | output | 1 | High while a walk is in progress |
| memAddr | output | ADDR_W | Memory address: base + current offset |

## Verification
A wrong accumulator value shows up on `memAddr` in the first cycle after the edge that caused it, because the address is a combinational sum of two registers. A corrupted bound or busy state shows up as a walk one access too long or too short: `busy` falls in the wrong cycle after the final `accessDone`. A preset that was loaded wrongly, or that a write during a walk disturbed, stays hidden until a later launch or until the base is used. For that reason, the randomized sequences relaunch walks often, and the bench compares every cycle.

// File: rtl/agen_pkg.sv
package agen_pkg;

  typedef enum logic [1:0] {
    SLOT_BASE   = 2'b00,
    SLOT_FIRST  = 2'b01,
    SLOT_LAST   = 2'b10,
    SLOT_LAUNCH = 2'b11
  } agenSlot_e;

  typedef struct packed {
    logic ldBase;
    logic ldFirst;
    logic ldLast;
    logic ldAcc;
    logic incAcc;
  } agenStrobes_t;

  typedef struct packed {
    logic firstLeLast;
    logic nextOver;
  } agenStatus_t;

endpackage

// File: rtl/agen_ctrl.sv
module agen_ctrl
  import agen_pkg::*;
#(
  parameter int SYS_AW = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sysWrEn,
  input  logic [SYS_AW-1:0] sysAddr,
  input  logic              accessDone,
  input  agenStatus_t       status,
  output agenStrobes_t      strobes,
  output logic              busy
);

  typedef enum logic {ST_IDLE = 1'b0, ST_WALK = 1'b1} walkState_e;

  walkState_e state;
  walkState_e stateNext;
  agenSlot_e  slot;
  logic       wrOk;
  logic       launchOk;
  logic       lastStep;

  assign slot     = agenSlot_e'(sysAddr[SYS_AW-1 -: 2]);
  assign wrOk     = sysWrEn && (state == ST_IDLE);
  assign launchOk = wrOk && (slot == SLOT_LAUNCH) && status.firstLeLast;
  assign lastStep = (state == ST_WALK) && accessDone && status.nextOver;

  always_comb begin
    strobes         = '0;
    strobes.ldBase  = wrOk && (slot == SLOT_BASE);
    strobes.ldFirst = wrOk && (slot == SLOT_FIRST);
    strobes.ldLast  = wrOk && (slot == SLOT_LAST);
    strobes.ldAcc   = launchOk;
    strobes.incAcc  = (state == ST_WALK) && accessDone && !status.nextOver;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (launchOk) stateNext = ST_WALK;
      ST_WALK: if (lastStep) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state == ST_WALK);

  // R6
  last_step_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && accessDone && status.nextOver) |=> !busy);

  // R7
  empty_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && sysWrEn && slot == SLOT_LAUNCH && !status.firstLeLast) |=> !busy);

  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !accessDone) |=> busy);

endmodule

// File: rtl/agen_dpath.sv
module agen_dpath
  import agen_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] sysData,
  input  agenStrobes_t      strobes,
  output agenStatus_t       status,
  output logic [ADDR_W-1:0] memAddr,
  output logic [OFS_W-1:0]  curOfs,
  output logic [OFS_W-1:0]  firstOfs,
  output logic [OFS_W-1:0]  lastOfs,
  output logic [ADDR_W-1:0] baseAddr
);

  localparam int NEXT_W = OFS_W + 1;

  logic [NEXT_W-1:0] accPlus;
  logic [ADDR_W-1:0] accExt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr <= '0;
      firstOfs <= '0;
      lastOfs  <= '0;
      curOfs   <= '0;
    end else begin
      if (strobes.ldBase)  baseAddr <= sysData;
      if (strobes.ldFirst) firstOfs <= sysData[OFS_W-1:0];
      if (strobes.ldLast)  lastOfs  <= sysData[OFS_W-1:0];
      if (strobes.ldAcc)       curOfs <= firstOfs;
      else if (strobes.incAcc) curOfs <= accPlus[OFS_W-1:0];
    end
  end

  assign accPlus = {1'b0, curOfs} + NEXT_W'(1);

  always_comb begin
    status             = '0;
    status.firstLeLast = (firstOfs <= lastOfs);
    status.nextOver    = (accPlus > {1'b0, lastOfs});
  end

  always_comb begin
    accExt              = '0;
    accExt[OFS_W-1:0]   = curOfs;
  end

  assign memAddr = baseAddr + accExt;

  // R8
  idle_offset_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.ldAcc && !strobes.incAcc) |=> $stable(curOfs));

endmodule

// File: rtl/bounded_offset_agen.sv
module bounded_offset_agen
  import agen_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 8,
  parameter int SYS_AW = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sysWrEn,
  input  logic [SYS_AW-1:0] sysAddr,
  input  logic [ADDR_W-1:0] sysData,
  input  logic              accessDone,
  output logic              busy,
  output logic [ADDR_W-1:0] memAddr
);

  agenStrobes_t      strobes;
  agenStatus_t       status;
  logic [OFS_W-1:0]  curOfs;
  logic [OFS_W-1:0]  firstOfs;
  logic [OFS_W-1:0]  lastOfs;
  logic [ADDR_W-1:0] baseAddr;

  agen_ctrl #(.SYS_AW(SYS_AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .sysWrEn(sysWrEn), .sysAddr(sysAddr),
    .accessDone(accessDone), .status(status), .strobes(strobes), .busy(busy)
  );

  agen_dpath #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_dpath (
    .clk(clk), .rstN(rstN), .sysData(sysData), .strobes(strobes),
    .status(status), .memAddr(memAddr), .curOfs(curOfs),
    .firstOfs(firstOfs), .lastOfs(lastOfs), .baseAddr(baseAddr)
  );

  // R5
  window_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (curOfs >= firstOfs && curOfs <= lastOfs));

  // R4
  launch_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (curOfs == firstOfs));

  // R5
  step_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && accessDone && curOfs != lastOfs) |=> (curOfs == $past(curOfs) + OFS_W'(1)));

  // R8
  presets_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(baseAddr) && $stable(firstOfs) && $stable(lastOfs)));

endmodule

// File: tb/sim_bounded_offset_agen.sv
module sim_bounded_offset_agen;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int OFS_W  = 8;
  localparam int SYS_AW = 4;

  logic              clk = 1'b0;
  logic              rstN;
  logic              sysWrEn;
  logic [SYS_AW-1:0] sysAddr;
  logic [ADDR_W-1:0] sysData;
  logic              accessDone;
  logic              busy;
  logic [ADDR_W-1:0] memAddr;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  logic [ADDR_W-1:0] mBase;
  logic [OFS_W-1:0]  mFirst, mLast, mOfs;
  logic              mBusy;

  bounded_offset_agen #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .SYS_AW(SYS_AW)) u0 (
    .clk(clk), .rstN(rstN), .sysWrEn(sysWrEn), .sysAddr(sysAddr),
    .sysData(sysData), .accessDone(accessDone), .busy(busy), .memAddr(memAddr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [ADDR_W-1:0] expAddr();
    logic [ADDR_W-1:0] e;
    e = '0;
    e[OFS_W-1:0] = mOfs;
    return mBase + e;
  endfunction

  task automatic modelEdge(input logic wr, input logic [1:0] slot,
                           input logic [ADDR_W-1:0] d, input logic done);
    logic [OFS_W:0] nxt;
    if (mBusy) begin
      if (done) begin
        nxt = {1'b0, mOfs} + 1;
        if (nxt > {1'b0, mLast}) mBusy = 1'b0;
        else mOfs = nxt[OFS_W-1:0];
      end
    end else if (wr) begin
      case (slot)
        2'b00: mBase  = d;
        2'b01: mFirst = d[OFS_W-1:0];
        2'b10: mLast  = d[OFS_W-1:0];
        default: if (mFirst <= mLast) begin mBusy = 1'b1; mOfs = mFirst; end
      endcase
    end
  endtask

  task automatic check(input string req);
    nChecks++;
    if (busy !== mBusy || memAddr !== expAddr()) begin
      nFails++;
      $display("FAIL %s: busy=%0b memAddr=%h expected busy=%0b memAddr=%h",
               req, busy, memAddr, mBusy, expAddr());
    end
  endtask

  task automatic step(input logic wr, input logic [1:0] slot,
                      input logic [ADDR_W-1:0] d, input logic done, input string req);
    @(negedge clk);
    sysWrEn    = wr;
    sysAddr    = {slot, {(SYS_AW-2){1'b0}}} | SYS_AW'($urandom % 4);
    sysData    = d;
    accessDone = done;
    @(posedge clk);
    modelEdge(wr, slot, d, done);
    #1;
    check(req);
  endtask

  task automatic idle(input string req);
    step(1'b0, 2'b00, '0, 1'b0, req);
  endtask

  task automatic walkOut(input string req);
    for (int i = 0; i < 300 && mBusy; i++) step(1'b0, 2'b00, '0, 1'b1, req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rstN = 1'b0; sysWrEn = 1'b0; sysAddr = '0; sysData = '0; accessDone = 1'b0;
    mBase = '0; mFirst = '0; mLast = '0; mOfs = '0; mBusy = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1; check("R1");

    // R2, R3, R4: program and launch window 3..6
    step(1'b1, 2'b00, 16'h1000, 1'b0, "R2");
    step(1'b1, 2'b01, 16'h0003, 1'b0, "R3");
    step(1'b1, 2'b10, 16'h0006, 1'b0, "R3");
    step(1'b1, 2'b11, 16'h0000, 1'b0, "R4");
    // R5: hold without pulse, then steps
    idle("R5");
    step(1'b0, 2'b00, '0, 1'b1, "R5");
    step(1'b0, 2'b00, '0, 1'b1, "R5");
    // R8: writes while busy ignored, including relaunch
    step(1'b1, 2'b00, 16'hFFFF, 1'b0, "R8");
    step(1'b1, 2'b11, 16'h0000, 1'b0, "R8");
    step(1'b0, 2'b00, '0, 1'b1, "R5");
    step(1'b0, 2'b00, '0, 1'b1, "R6");
    idle("R6");
    // R8: done while idle ignored
    step(1'b0, 2'b00, '0, 1'b1, "R8");
    // R3: update last only; relaunch starts at old first
    step(1'b1, 2'b10, 16'h0004, 1'b0, "R3");
    step(1'b1, 2'b11, 16'h0000, 1'b0, "R3");
    walkOut("R6");
    // R7: empty window
    step(1'b1, 2'b01, 16'h0009, 1'b0, "R3");
    step(1'b1, 2'b11, 16'h0000, 1'b0, "R7");
    idle("R7");
    // single-entry window
    step(1'b1, 2'b10, 16'h0009, 1'b0, "R3");
    step(1'b1, 2'b11, 16'h0000, 1'b0, "R4");
    step(1'b0, 2'b00, '0, 1'b1, "R6");
    // R9: address wrap
    step(1'b1, 2'b00, 16'hFFF0, 1'b0, "R9");
    step(1'b1, 2'b01, 16'h0020, 1'b0, "R9");
    step(1'b1, 2'b10, 16'h0022, 1'b0, "R9");
    step(1'b1, 2'b11, 16'h0000, 1'b0, "R9");
    walkOut("R9");
    // R10: window ending at all-ones offset
    step(1'b1, 2'b01, 16'h00FE, 1'b0, "R10");
    step(1'b1, 2'b10, 16'h00FF, 1'b0, "R10");
    step(1'b1, 2'b11, 16'h0000, 1'b0, "R10");
    step(1'b0, 2'b00, '0, 1'b1, "R10");
    step(1'b0, 2'b00, '0, 1'b1, "R10");
    idle("R10");

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [1:0]        s;
      logic [ADDR_W-1:0] d;
      s = 2'($urandom % 4);
      d = 16'($urandom);
      if (s != 2'b00 && ($urandom % 8) != 0) d = 16'($urandom % 24);
      step(($urandom % 3) != 0, s, d, ($urandom % 2) != 0, "R5");
    end
    walkOut("R6");

    // R1: reset mid-walk
    step(1'b1, 2'b01, 16'h0001, 1'b0, "R3");
    step(1'b1, 2'b10, 16'h0010, 1'b0, "R3");
    step(1'b1, 2'b11, 16'h0000, 1'b0, "R4");
    @(negedge clk); rstN = 1'b0;
    @(posedge clk);
    mBase = '0; mFirst = '0; mLast = '0; mOfs = '0; mBusy = 1'b0;
    #1; check("R1");
    @(negedge clk); rstN = 1'b1;

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule